// File: doc/BRIEF.md
# Exit-Time Register Load Walker

This block runs through a list of register-load entries during the exit sequence from a guest context back to the host. Software sets up the list in a small memory. The walker gets a base address and an entry count with a one-cycle start pulse. It then reads the entries one by one through a valid/ready memory read port. Each entry is 128 bits wide and occupies one memory word. Entry n sits at address base + n, and the address wraps at the address width.

Each fetched entry is screened against a set of rejection rules. An entry that passes becomes one write request carrying a 32-bit register index and a 64-bit value. The write target can answer that request with a fault. The first entry that is rejected or faulted stops the walk at once, and nothing after it is fetched or written. The block then raises abort and reports the zero-based number of the entry that failed. A walk with no failure ends with done raised and abort low.

Top module: `reg_list_walker`

## Requirements
- R1: Entries are fetched in list order, one at a time, with entry n read from address base_addr + n. A fetch request keeps mem_req_valid and mem_req_addr steady until mem_req_ready is seen.
- R2: Entry bits 31:0 are the register index and bits 127:64 are the value. Each passing entry produces exactly one write request carrying that index and value, and the writes appear in list order.
- R3: An entry whose bits 63:32 are not all zero is rejected.
- R4: An entry whose index is 32'hC000_0100 or 32'hC000_0101 (the two segment-base registers) is rejected.
- R5: An entry whose index bits 31:8 equal 24'h000008 is rejected. This is the interrupt-controller register window.
- R6: An entry whose index equals the parameter MGMT_ONLY_IDX (default 32'h0000_009B) is rejected if exit_in_mgmt_mode, sampled at start, was 0. The same entry is accepted if that input was 1.
- R7: An entry whose index equals an enabled slot of the four-slot deny list is rejected. Slot k occupies deny_idx[32k+31:32k] and is enabled by deny_en[k]. A disabled slot never matches.
- R8: If wr_fault is high in the cycle that wr_ready accepts a write, that entry fails.
- R9: On any failure the walk stops. A rejected entry issues no write, and no later entry is fetched. done and abort both go to 1, and fail_entry holds the failing entry's zero-based number.
- R10: A walk with no failure ends with done=1 and abort=0 after its last write. With entry_count of 0, done=1 is shown in the cycle after start, and no fetch or write takes place.
- R11: A start pulse while busy is ignored. done, abort and fail_entry keep their values until the next accepted start, which clears them.
- R12: After reset, busy, done, abort, mem_req_valid and wr_valid are 0.
- R13: A write request keeps wr_valid, wr_index and wr_value steady until wr_ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a walk when idle |
| base_addr | input | AW | Word address of entry 0 |
| entry_count | input | CW | Number of entries to apply |
| exit_in_mgmt_mode | input | 1 | The exit ends in management mode (sampled at start) |
| deny_en | input | DENY_N | Enable bits for the deny slots |
| deny_idx | input | 32*DENY_N | Packed deny indices, slot k at bits 32k+31:32k |
| mem_req_valid | output | 1 | Fetch request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | AW | Fetch word address |
| mem_rsp_valid | input | 1 | Fetched word is present |
| mem_rsp_data | input | 128 | Fetched entry |
| wr_valid | output | 1 | Register write request |
| wr_ready | input | 1 | Write target accepts the write |
| wr_index | output | 32 | Register index |
| wr_value | output | 64 | Register value |
| wr_fault | input | 1 | Write target reports a protection fault |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | The walk has ended |
| abort | output | 1 | The walk ended on a failure |
| fail_entry | output | CW | Number of the failing entry |

## Verification
A wrong entry counter or base register shows up as a wrong mem_req_addr at the very next fetch handshake. A lost or stale entry register shows up as a mismatched index or value at the next write handshake, at most a few cycles later. A rule that evaluates wrongly either lets a write through that the scoreboard does not expect, or stops the walk early, which leaves expected writes unconsumed and gives a wrong fail_entry when done rises. A sequencer that misses its final state leaves busy high, and the per-walk cycle limit catches it within a few thousand cycles.

// File: rtl/rlw_pkg.sv
package rlw_pkg;

  localparam logic [31:0] SEG_BASE_LO = 32'hC000_0100;
  localparam logic [31:0] SEG_BASE_HI = 32'hC000_0101;
  localparam logic [23:0] IRQ_WINDOW  = 24'h00_0008;

  typedef struct packed {
    logic [63:0] value;
    logic [31:0] resv;
    logic [31:0] index;
  } rlw_entry_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT,
    ST_CHECK,
    ST_WRITE
  } rlw_state_t;

  typedef enum logic [2:0] {
    RJ_NONE,
    RJ_RESV,
    RJ_SEG,
    RJ_WIN,
    RJ_MODE,
    RJ_DENY
  } rlw_reason_t;

  function automatic logic resv_nonzero(input rlw_entry_t e);
    return |e.resv;
  endfunction

  function automatic logic is_seg_base(input logic [31:0] idx);
    return (idx == SEG_BASE_LO) || (idx == SEG_BASE_HI);
  endfunction

  function automatic logic in_irq_window(input logic [31:0] idx);
    return idx[31:8] == IRQ_WINDOW;
  endfunction

  function automatic logic mode_forbids(input logic [31:0] idx,
                                        input logic [31:0] mgmt_idx,
                                        input logic        ends_in_mgmt);
    return (idx == mgmt_idx) && !ends_in_mgmt;
  endfunction

endpackage

// File: rtl/rlw_rule_check.sv
module rlw_rule_check
  import rlw_pkg::*;
#(
  parameter int          DENY_N        = 4,
  parameter logic [31:0] MGMT_ONLY_IDX = 32'h0000_009B
) (
  input  rlw_entry_t              ent,
  input  logic                    ends_in_mgmt,
  input  logic [DENY_N-1:0]       deny_en,
  input  logic [DENY_N*32-1:0]    deny_idx,
  output logic                    reject,
  output rlw_reason_t             reason
);

  logic [DENY_N-1:0] deny_hit;

  for (genvar g = 0; g < DENY_N; g++) begin : g_deny
    assign deny_hit[g] = deny_en[g] && (deny_idx[g*32 +: 32] == ent.index);
  end

  always_comb begin
    reason = RJ_NONE;
    if (resv_nonzero(ent))                                   reason = RJ_RESV;
    else if (is_seg_base(ent.index))                         reason = RJ_SEG;
    else if (in_irq_window(ent.index))                       reason = RJ_WIN;
    else if (mode_forbids(ent.index, MGMT_ONLY_IDX, ends_in_mgmt)) reason = RJ_MODE;
    else if (|deny_hit)                                      reason = RJ_DENY;
  end

  assign reject = (reason != RJ_NONE);

endmodule

// File: rtl/rlw_fetch_port.sv
module rlw_fetch_port
  import rlw_pkg::*;
#(
  parameter int AW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_base,
  input  logic [AW-1:0] base_in,
  input  logic [CW-1:0] cur,
  input  logic          fetch_on,
  input  logic          wait_on,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [127:0]  mem_rsp_data,
  output logic          req_fire,
  output logic          rsp_fire,
  output rlw_entry_t    entry_q
);

  localparam int SW = AW + CW;

  logic [AW-1:0] base_q;
  logic [SW-1:0] addr_sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         base_q <= '0;
    else if (load_base) base_q <= base_in;
  end

  assign addr_sum      = {{CW{1'b0}}, base_q} + {{AW{1'b0}}, cur};
  assign mem_req_addr  = addr_sum[AW-1:0];
  assign mem_req_valid = fetch_on;
  assign req_fire      = fetch_on && mem_req_ready;
  assign rsp_fire      = wait_on && mem_rsp_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        entry_q <= '0;
    else if (rsp_fire) entry_q <= rlw_entry_t'(mem_rsp_data);
  end

endmodule

// File: rtl/rlw_seq.sv
module rlw_seq
  import rlw_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] entry_count,
  input  logic          exit_in_mgmt_mode,
  input  logic          req_fire,
  input  logic          rsp_fire,
  input  logic          reject,
  input  logic          wr_ready,
  input  logic          wr_fault,
  output rlw_state_t    state,
  output logic [CW-1:0] cur,
  output logic          mgmt_q,
  output logic          done,
  output logic          abort,
  output logic [CW-1:0] fail_entry,
  output logic          ev_accept,
  output logic          ev_reject,
  output logic          ev_wr_ok,
  output logic          ev_wr_fault,
  output logic          ev_finish
);

  logic [CW-1:0] cnt_q;
  logic [CW:0]   next_cur;
  logic          last;

  assign next_cur    = {1'b0, cur} + 1'b1;
  assign last        = (next_cur == {1'b0, cnt_q});
  assign ev_accept   = (state == ST_IDLE) && start;
  assign ev_reject   = (state == ST_CHECK) && reject;
  assign ev_wr_ok    = (state == ST_WRITE) && wr_ready && !wr_fault;
  assign ev_wr_fault = (state == ST_WRITE) && wr_ready && wr_fault;
  assign ev_finish   = ev_reject || ev_wr_fault || (ev_wr_ok && last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cur        <= '0;
      cnt_q      <= '0;
      mgmt_q     <= 1'b0;
      done       <= 1'b0;
      abort      <= 1'b0;
      fail_entry <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          done       <= (entry_count == '0);
          abort      <= 1'b0;
          fail_entry <= '0;
          cur        <= '0;
          cnt_q      <= entry_count;
          mgmt_q     <= exit_in_mgmt_mode;
          if (entry_count != '0) state <= ST_FETCH;
        end
        ST_FETCH: if (req_fire) state <= ST_WAIT;
        ST_WAIT:  if (rsp_fire) state <= ST_CHECK;
        ST_CHECK: begin
          if (reject) begin
            state      <= ST_IDLE;
            done       <= 1'b1;
            abort      <= 1'b1;
            fail_entry <= cur;
          end else begin
            state <= ST_WRITE;
          end
        end
        ST_WRITE: if (wr_ready) begin
          if (wr_fault) begin
            state      <= ST_IDLE;
            done       <= 1'b1;
            abort      <= 1'b1;
            fail_entry <= cur;
          end else if (last) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            cur   <= next_cur[CW-1:0];
            state <= ST_FETCH;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/reg_list_walker.sv
module reg_list_walker
  import rlw_pkg::*;
#(
  parameter int          AW            = 8,
  parameter int          CW            = 8,
  parameter int          DENY_N        = 4,
  parameter logic [31:0] MGMT_ONLY_IDX = 32'h0000_009B
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [AW-1:0]        base_addr,
  input  logic [CW-1:0]        entry_count,
  input  logic                 exit_in_mgmt_mode,
  input  logic [DENY_N-1:0]    deny_en,
  input  logic [DENY_N*32-1:0] deny_idx,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  output logic [AW-1:0]        mem_req_addr,
  input  logic                 mem_rsp_valid,
  input  logic [127:0]         mem_rsp_data,
  output logic                 wr_valid,
  input  logic                 wr_ready,
  output logic [31:0]          wr_index,
  output logic [63:0]          wr_value,
  input  logic                 wr_fault,
  output logic                 busy,
  output logic                 done,
  output logic                 abort,
  output logic [CW-1:0]        fail_entry
);

  rlw_state_t  state;
  rlw_entry_t  entry_q;
  rlw_reason_t reason;
  logic [CW-1:0] cur;
  logic mgmt_q, req_fire, rsp_fire, reject;
  logic ev_accept, ev_reject, ev_wr_ok, ev_wr_fault, ev_finish;

  rlw_seq #(.CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .entry_count(entry_count),
    .exit_in_mgmt_mode(exit_in_mgmt_mode), .req_fire(req_fire),
    .rsp_fire(rsp_fire), .reject(reject), .wr_ready(wr_ready),
    .wr_fault(wr_fault), .state(state), .cur(cur), .mgmt_q(mgmt_q),
    .done(done), .abort(abort), .fail_entry(fail_entry),
    .ev_accept(ev_accept), .ev_reject(ev_reject), .ev_wr_ok(ev_wr_ok),
    .ev_wr_fault(ev_wr_fault), .ev_finish(ev_finish)
  );

  rlw_fetch_port #(.AW(AW), .CW(CW)) u_fetch (
    .clk(clk), .rst_n(rst_n), .load_base(ev_accept), .base_in(base_addr),
    .cur(cur), .fetch_on(state == ST_FETCH), .wait_on(state == ST_WAIT),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .req_fire(req_fire), .rsp_fire(rsp_fire),
    .entry_q(entry_q)
  );

  rlw_rule_check #(.DENY_N(DENY_N), .MGMT_ONLY_IDX(MGMT_ONLY_IDX)) u_rules (
    .ent(entry_q), .ends_in_mgmt(mgmt_q), .deny_en(deny_en),
    .deny_idx(deny_idx), .reject(reject), .reason(reason)
  );

  assign wr_valid = (state == ST_WRITE);
  assign wr_index = entry_q.index;
  assign wr_value = entry_q.value;
  assign busy     = (state != ST_IDLE);

endmodule

// File: rtl/rlw_checker.sv
module rlw_checker #(
  parameter int AW = 8,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [CW-1:0] entry_count,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [AW-1:0] mem_req_addr,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [31:0]   wr_index,
  input logic [63:0]   wr_value,
  input logic          busy,
  input logic          done,
  input logic          abort,
  input logic [CW-1:0] fail_entry,
  input logic          ev_reject,
  input logic          ev_finish
);

  a_r1_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  a_r13_write_held: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_index) && $stable(wr_value));

  a_r4_no_seg_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_index != 32'hC000_0100) && (wr_index != 32'hC000_0101));

  a_r5_no_window_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_index[31:8] != 24'h00_0008);

  a_r9_reject_halts: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reject |=> !busy && done && abort && !wr_valid && !mem_req_valid);

  a_r9_abort_has_done: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> done);

  a_r10_quiet_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req_valid && !wr_valid);

  a_r10_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && (entry_count == '0) |=> done && !abort && !busy);

  a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !ev_finish |=> busy && $stable(fail_entry) && !done);

  a_r11_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(abort) && $stable(fail_entry));

endmodule

bind reg_list_walker rlw_checker #(.AW(AW), .CW(CW)) u_rlw_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .entry_count(entry_count),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_index(wr_index), .wr_value(wr_value), .busy(busy), .done(done),
  .abort(abort), .fail_entry(fail_entry), .ev_reject(ev_reject),
  .ev_finish(ev_finish)
);

// File: tb/tb_reg_list_walker.sv
`timescale 1ns/1ps
module tb_reg_list_walker;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] base_addr = '0;
  logic [7:0] entry_count = '0;
  logic exit_in_mgmt_mode = 1'b0;
  logic [3:0] deny_en = '0;
  logic [127:0] deny_idx = '0;
  logic mem_req_valid, mem_req_ready = 1'b0;
  logic [7:0] mem_req_addr;
  logic mem_rsp_valid = 1'b0;
  logic [127:0] mem_rsp_data = '0;
  logic wr_valid, wr_ready = 1'b0;
  logic [31:0] wr_index;
  logic [63:0] wr_value;
  logic wr_fault = 1'b0;
  logic busy, done, abort;
  logic [7:0] fail_entry;

  always #2 clk = ~clk;

  reg_list_walker dut (.*);

  int n_chk = 0, n_bad = 0, cyc = 0, fetches = 0;
  bit finished = 0;
  logic [127:0] mem [256];
  logic [95:0]  expq [$];
  logic [7:0]   exp_addr;
  logic [31:0]  fault_idx = 32'hFFFF_FFFF;
  logic [31:0]  dlist [4];
  logic [3:0]   den = '0;

  task automatic chk(input bit ok, input string req,
                     input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit bench_bad(input logic [127:0] e, input bit mgmt);
    logic [31:0] ix = e[31:0];
    if (e[63:32] != 32'd0) return 1;                 // R3
    if (ix[31:1] == 31'h6000_0080) return 1;         // R4
    if (ix >= 32'h800 && ix <= 32'h8FF) return 1;    // R5
    if (ix == 32'h9B && !mgmt) return 1;             // R6
    for (int k = 0; k < 4; k++)
      if (den[k] && dlist[k] == ix) return 1;        // R7
    return 0;
  endfunction

  function automatic logic [127:0] mk(input logic [31:0] ix,
                                      input logic [31:0] rs,
                                      input logic [63:0] v);
    return {v, rs, ix};
  endfunction

  // responder and scoreboard monitor (memory side and write side)
  int mem_cnt = 0, wr_wait = 0;
  bit mem_pend = 0;
  logic [7:0] pend_addr;
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_n) begin
        mem_rsp_valid = 1'b0;
        if (mem_pend) begin
          if (mem_cnt == 0) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = mem[pend_addr];
            mem_pend      = 0;
          end else mem_cnt--;
        end
        mem_req_ready = (cyc % 4) != 1;
        if (mem_req_valid && mem_req_ready) begin
          chk(mem_req_addr == exp_addr, "R1 fetch address",
              96'(mem_req_addr), 96'(exp_addr));
          exp_addr++;
          fetches++;
          mem_pend  = 1;
          pend_addr = mem_req_addr;
          mem_cnt   = cyc % 3;
        end
        if (wr_ready) begin
          wr_ready = 1'b0;
          wr_fault = 1'b0;
        end else if (wr_valid) begin
          if (wr_wait == 0) begin
            wr_ready = 1'b1;
            wr_fault = (wr_index == fault_idx);
            wr_wait  = cyc % 3;
            if (expq.size() == 0)
              chk(0, "R2 unexpected write", {wr_index, wr_value}, 96'd0);
            else begin
              logic [95:0] e;
              e = expq.pop_front();
              chk({wr_index, wr_value} == e, "R2 write content",
                  {wr_index, wr_value}, e);
            end
          end else wr_wait--;
        end
      end
    end
  end

  task automatic run_walk(input logic [7:0] b, input int n, input bit mgmt,
                          input bit inject, input string tag);
    bit ab = 0;
    int fi = 0, exp_fetch;
    for (int i = 0; i < n; i++) begin
      logic [127:0] e;
      e = mem[8'(b + i)];
      if (bench_bad(e, mgmt)) begin ab = 1; fi = i; break; end
      expq.push_back({e[31:0], e[127:64]});
      if (e[31:0] == fault_idx) begin ab = 1; fi = i; break; end
    end
    exp_fetch = ab ? fi + 1 : n;
    @(negedge clk);
    exp_addr = b; fetches = 0;
    base_addr = b; entry_count = 8'(n); exit_in_mgmt_mode = mgmt;
    deny_en = den;
    for (int k = 0; k < 4; k++) deny_idx[k*32 +: 32] = dlist[k];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (inject) begin
      @(negedge clk);
      start = 1'b1; entry_count = 8'd0; base_addr = 8'd0;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, {tag, " R11 busy after ignored start"}, 96'(busy), 96'd1);
    end
    for (int t = 0; t < 3000 && !done; t++) @(negedge clk);
    chk(done == 1'b1, {tag, " R10 done"}, 96'(done), 96'd1);
    chk(abort == ab, {tag, " R9 abort"}, 96'(abort), 96'(ab));
    if (ab) chk(fail_entry == 8'(fi), {tag, " R9 fail_entry"},
                96'(fail_entry), 96'(fi));
    chk(expq.size() == 0, {tag, " R2 writes missing"}, 96'(expq.size()), 96'd0);
    chk(fetches == exp_fetch, {tag, " R9 fetch count"}, 96'(fetches), 96'(exp_fetch));
    expq.delete();
    repeat (4) @(negedge clk);
    chk(done && abort == ab && (!ab || fail_entry == 8'(fi)),
        {tag, " R11 result held"}, 96'({done, abort}), 96'({1'b1, ab}));
  endtask

  initial begin
    for (int a = 0; a < 256; a++)
      mem[a] = mk(32'h1000 + 32'(a), 32'd0, {32'hA5A5_0000, 32'(a) * 32'h0101});
    for (int k = 0; k < 4; k++) dlist[k] = 32'h0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(!busy && !done && !abort && !mem_req_valid && !wr_valid, "R12 reset outputs",
        96'({busy, done, abort, mem_req_valid, wr_valid}), 96'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_walk(8'd8, 4, 0, 0, "T1 plain");                          // R1 R2 R10
    run_walk(8'd250, 9, 0, 0, "T1b wrap");                        // R1 address wrap
    mem[22] = mk(32'h2222, 32'h0000_0100, 64'h1);                 // R3
    run_walk(8'd20, 5, 0, 0, "T2 resv");
    mem[30] = mk(32'hC000_0101, 32'd0, 64'h2);                    // R4
    run_walk(8'd30, 3, 0, 0, "T3 segbase");
    mem[43] = mk(32'h0000_0830, 32'd0, 64'h3);                    // R5
    run_walk(8'd40, 6, 0, 0, "T4 window");
    mem[51] = mk(32'h0000_009B, 32'd0, 64'h4);                    // R6
    run_walk(8'd50, 4, 0, 0, "T5 mode reject");
    run_walk(8'd50, 4, 1, 0, "T5 mode accept");
    dlist[0] = 32'h1000 + 32'd62; dlist[2] = 32'h1000 + 32'd61;    // R7
    den = 4'b0001;
    run_walk(8'd60, 4, 0, 0, "T6 deny hit");
    den = 4'b0010; dlist[1] = 32'h1000 + 32'd62;
    run_walk(8'd60, 4, 0, 0, "T6 deny hit slot1");
    den = 4'b1000;
    run_walk(8'd60, 4, 0, 0, "T6 deny disabled");
    den = 4'b0000;
    fault_idx = 32'h1000 + 32'd71;                                // R8
    run_walk(8'd70, 5, 0, 0, "T7 fault");
    fault_idx = 32'hFFFF_FFFF;
    run_walk(8'd80, 5, 0, 1, "T9 start while busy");              // R11

    // R10 zero count
    @(negedge clk);
    fetches = 0;
    entry_count = 8'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done && !abort && !busy, "R10 zero count done", 96'({done, abort, busy}), 96'b100);
    repeat (3) @(negedge clk);
    chk(fetches == 0, "R10 zero count no fetch", 96'(fetches), 96'd0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule